// File: doc/BRIEF.md
# Infrared Frame Receive Status Tracker

This block sits on the path from a fast-mode infrared receive decoder to the receive byte queue. It keeps the per-frame receive status. The decoder hands it one byte at a time, along with a frame-start flag, a frame-end flag and a separate strobe for an illegal line symbol. A CRC checker reports the pass or fail result once per frame.

The block stores accepted bytes in an internal queue. Each entry carries a tag that marks the final byte of a frame, so several frames can wait in the queue and still be told apart. A programmable 16-bit length limit stops a runaway frame. An illegal symbol closes the frame in progress.

A host reads one status byte. It shows:
- the end-of-frame tag of the entry at the read head;
- two transmitter-empty bits, passed straight through;
- four sticky error flags;
- a data-ready bit.

Reading the status byte clears the sticky flags.

Top module: `irrx_frame_status`

## Requirements
- R1: After a synchronous reset, status bits 7 and 4..0 are 0, the queue is empty, and no frame is open.
- R2: The status byte is laid out as follows, from bit 7 down to bit 0:
  - bit 7: head end-of-frame tag;
  - bit 6: transmit shift empty;
  - bit 5: transmit holding empty;
  - bit 4: length exceeded;
  - bit 3: physical-layer error;
  - bit 2: CRC error;
  - bit 1: overrun;
  - bit 0: data ready.
- R3: An accepted byte that has `dec_eof` high is stored with its end tag set. Status bit 7 is 1 exactly when the queue is non-empty and the entry at the read head carries the end tag. `fifo_rd_last` returns that tag together with the popped byte.
- R4: A byte with `dec_sof` high sets the frame byte count to 1. Each later byte of the frame adds 1 to the count. The count saturates at 65535. When the count exceeds {`max_len_hi`,`max_len_lo`} (unsigned greater-than), bit 4 is set.
- R5: Once the length is exceeded, no further byte of that frame is written to the queue. This includes the byte that exceeded the limit. Writing resumes with the next `dec_sof` byte.
- R6: A `dec_illegal` strobe does three things:
  - it sets bit 3;
  - it closes the open frame and discards any byte presented in the same cycle;
  - if the frame has already written a byte that is still queued, it sets the end tag of that most recent byte. If the frame wrote no byte, nothing is tagged.
- R7: When `crc_done` and `crc_bad` are both high, bit 2 is set.
- R8: Bit 0 is 1 while the queue holds at least one byte. An accepted byte that arrives while the queue is full at the start of the cycle is dropped and sets bit 1, even if a pop happens in the same cycle.
- R9: Bits 4..1 are sticky. A `stat_rd` pulse clears them at the next edge. A flag that is set in the same cycle as the read stays set.
- R10: A byte that arrives while no frame is open and without `dec_sof` is ignored.
- R11: `fifo_rd` pops the head entry, and `fifo_rd_data`/`fifo_rd_last` show that entry one cycle later. `fifo_rd` on an empty queue has no effect.
- R12: Status bits 6 and 5 follow `tx_shift_empty` and `tx_hold_empty` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_vld | input | 1 | Decoded byte valid |
| dec_byte | input | 8 | Decoded byte |
| dec_sof | input | 1 | Byte is the first of a frame |
| dec_eof | input | 1 | Byte is the last of a frame |
| dec_illegal | input | 1 | Illegal line symbol strobe |
| crc_done | input | 1 | CRC result valid strobe |
| crc_bad | input | 1 | CRC check failed |
| max_len_lo | input | 8 | Length limit, low byte |
| max_len_hi | input | 8 | Length limit, high byte |
| tx_shift_empty | input | 1 | Transmitter shift register empty |
| tx_hold_empty | input | 1 | Transmitter holding register empty |
| fifo_rd | input | 1 | Pop the head entry |
| fifo_rd_data | output | 8 | Popped byte |
| fifo_rd_last | output | 1 | End tag of the popped byte |
| stat_rd | input | 1 | Status read strobe (clears sticky flags) |
| status | output | 8 | Status byte |

## Verification
The hardest case to reach is an illegal symbol that arrives while a frame is open but has queued nothing. That needs a frame whose opening byte was refused. The stimulus gets there in two ways: by setting the length limit to 0, and by filling the queue before the frame starts. In both cases the bench checks that no earlier frame's byte gains a tag.

A second hard case is an illegal symbol in the same cycle that the tagged byte leaves the read head. A bench-side queue model that is compared every clock covers this, under long runs of mixed pops, reads and frame events.

// File: rtl/irrx_pkg.sv
package irrx_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned LEN_W   = 2 * BYTE_W;
  localparam int unsigned NFLAG   = 4;
  // sticky flag indices inside the flag vector
  localparam int unsigned F_OVR   = 0;
  localparam int unsigned F_CRC   = 1;
  localparam int unsigned F_PHY   = 2;
  localparam int unsigned F_LEN   = 3;
endpackage

// File: rtl/irrx_fifo.sv
module irrx_fifo
  import irrx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_last,
  input  logic              mark_en,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_last,
  output logic              head_last,
  output logic              not_empty,
  output logic              full
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  tag;
  logic [AW-1:0]     wptr, rptr;
  logic [AW:0]       count;
  logic              pop;

  assign not_empty = (count != '0);
  assign full      = (count == (AW+1)'(DEPTH));
  assign pop       = rd_en & not_empty;
  assign head_last = not_empty & tag[rptr];

  // data array: plain write port and registered read, no reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
    if (pop)   rd_data  <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag     <= '0;
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      rd_last <= 1'b0;
    end else begin
      if (wr_en) begin
        tag[wptr] <= wr_last;
        wptr      <= wptr + AW'(1);
      end
      if (mark_en) tag[wptr - AW'(1)] <= 1'b1;
      if (pop) begin
        rd_last <= tag[rptr];
        rptr    <= rptr + AW'(1);
      end
      count <= count + (AW+1)'(wr_en) - (AW+1)'(pop);
    end
  end

  // R8: the frame controller never pushes into a full queue
  p_no_push_full_r8: assert property (@(posedge clk) disable iff (rst) wr_en |-> !full);
  // R8: occupancy never exceeds the depth
  p_count_bound_r8: assert property (@(posedge clk) disable iff (rst) count <= (AW+1)'(DEPTH));
  // R6: a forced end never coincides with a push
  p_no_mark_push_r6: assert property (@(posedge clk) disable iff (rst) !(wr_en && mark_en));
endmodule

// File: rtl/irrx_frame_ctl.sv
module irrx_frame_ctl
  import irrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_vld,
  input  logic             sof,
  input  logic             eof,
  input  logic             illegal,
  input  logic [LEN_W-1:0] max_len,
  input  logic             full,
  output logic             wr_en,
  output logic             wr_last,
  output logic             mark_en,
  output logic             len_set,
  output logic             ovr_set
);
  localparam logic [LEN_W-1:0] CNT_MAX = '1;

  logic             in_frame, ovf_frame, has_byte;
  logic [LEN_W-1:0] cnt, cnt_nx;
  logic             take, over, blocked;

  always_comb begin
    take    = byte_vld & ~illegal & (sof | in_frame);
    cnt_nx  = sof ? LEN_W'(1) : ((cnt == CNT_MAX) ? cnt : cnt + LEN_W'(1));
    over    = cnt_nx > max_len;
    blocked = over | (ovf_frame & ~sof);
    wr_en   = take & ~blocked & ~full;
    ovr_set = take & ~blocked & full;
    len_set = take & over;
    mark_en = illegal & in_frame & has_byte;
    wr_last = eof;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame  <= 1'b0;
      ovf_frame <= 1'b0;
      has_byte  <= 1'b0;
      cnt       <= '0;
    end else if (illegal) begin
      in_frame <= 1'b0;
      has_byte <= 1'b0;
    end else if (take) begin
      cnt       <= cnt_nx;
      ovf_frame <= over | (ovf_frame & ~sof);
      in_frame  <= ~eof;
      has_byte  <= eof ? 1'b0 : ((has_byte & ~sof) | wr_en);
    end
  end

  // R5: after the limit trips, the next cycle writes nothing unless a new frame starts
  p_len_block_r5: assert property (@(posedge clk) disable iff (rst)
    len_set |=> (!wr_en || (byte_vld && sof)));
  // R4: the frame count saturates instead of wrapping
  p_cnt_nowrap_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt) == CNT_MAX && !($past(take) && $past(sof))) |-> cnt == CNT_MAX);
endmodule

// File: rtl/irrx_flags.sv
module irrx_flags
  import irrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set,
  input  logic             clr,
  output logic [NFLAG-1:0] flags
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flags[i] <= 1'b0;
      else     flags[i] <= (flags[i] & ~clr) | set[i];
    end
    // R9: a flag holds until a read clears it
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      ($past(flags[i]) && !$past(clr)) |-> flags[i]);
    // R9: a set in the read cycle wins over the clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
      $past(set[i]) |-> flags[i]);
  end
endmodule

// File: rtl/irrx_frame_status.sv
module irrx_frame_status
  import irrx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_vld,
  input  logic [BYTE_W-1:0] dec_byte,
  input  logic              dec_sof,
  input  logic              dec_eof,
  input  logic              dec_illegal,
  input  logic              crc_done,
  input  logic              crc_bad,
  input  logic [BYTE_W-1:0] max_len_lo,
  input  logic [BYTE_W-1:0] max_len_hi,
  input  logic              tx_shift_empty,
  input  logic              tx_hold_empty,
  input  logic              fifo_rd,
  output logic [BYTE_W-1:0] fifo_rd_data,
  output logic              fifo_rd_last,
  input  logic              stat_rd,
  output logic [7:0]        status
);
  logic             wr_en, wr_last, mark_en, len_set, ovr_set;
  logic             head_last, not_empty, full;
  logic [NFLAG-1:0] set_vec, flags;

  irrx_frame_ctl u_ctl (
    .clk(clk), .rst(rst), .byte_vld(dec_vld), .sof(dec_sof), .eof(dec_eof),
    .illegal(dec_illegal), .max_len({max_len_hi, max_len_lo}), .full(full),
    .wr_en(wr_en), .wr_last(wr_last), .mark_en(mark_en),
    .len_set(len_set), .ovr_set(ovr_set)
  );

  irrx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(dec_byte), .wr_last(wr_last),
    .mark_en(mark_en), .rd_en(fifo_rd), .rd_data(fifo_rd_data),
    .rd_last(fifo_rd_last), .head_last(head_last), .not_empty(not_empty), .full(full)
  );

  always_comb begin
    set_vec        = '0;
    set_vec[F_OVR] = ovr_set;
    set_vec[F_CRC] = crc_done & crc_bad;
    set_vec[F_PHY] = dec_illegal;
    set_vec[F_LEN] = len_set;
  end

  irrx_flags u_flags (.clk(clk), .rst(rst), .set(set_vec), .clr(stat_rd), .flags(flags));

  assign status = {head_last, tx_shift_empty, tx_hold_empty,
                   flags[F_LEN], flags[F_PHY], flags[F_CRC], flags[F_OVR], not_empty};

  // R6: an illegal symbol is visible as a physical error on the next cycle
  p_phy_set_r6: assert property (@(posedge clk) disable iff (rst) $past(dec_illegal) |-> status[3]);
  // R8: a pop from a single-entry queue with no push leaves it empty
  p_ready_drop_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(fifo_rd) && $past(status[0]) && !$past(dec_vld) && !$past(u_fifo.count > 1)) |-> !status[0]);
endmodule

// File: tb/tb_irrx_frame_status.sv
module tb_irrx_frame_status;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 0, rst = 1;
  logic dec_vld = 0, dec_sof = 0, dec_eof = 0, dec_illegal = 0;
  logic [7:0] dec_byte = 0, max_len_lo = 8'hFF, max_len_hi = 8'hFF;
  logic crc_done = 0, crc_bad = 0, tx_shift_empty = 0, tx_hold_empty = 0;
  logic fifo_rd = 0, stat_rd = 0;
  logic [7:0] fifo_rd_data, status;
  logic fifo_rd_last;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  irrx_frame_status #(.FIFO_DEPTH(DEPTH)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int q[$];
  bit m_in, m_ovf, m_has, f_len, f_phy, f_crc, f_ovr;
  int m_cnt, lim, cn, exp_rd;
  bit full0, over, blocked, wrote, exp_rd_vld;
  bit s_len, s_phy, s_crc, s_ovr;

  always @(posedge clk) begin
    exp_rd_vld = 0;
    if (rst) begin
      q.delete(); m_in = 0; m_ovf = 0; m_has = 0; m_cnt = 0;
      f_len = 0; f_phy = 0; f_crc = 0; f_ovr = 0;
    end else begin
      s_len = 0; s_phy = 0; s_crc = 0; s_ovr = 0;
      lim = {max_len_hi, max_len_lo};
      full0 = (q.size() == DEPTH);
      if (fifo_rd && q.size() > 0) begin exp_rd = q.pop_front(); exp_rd_vld = 1; end
      if (dec_illegal) begin
        s_phy = 1;
        if (m_in && m_has && q.size() > 0) q[q.size()-1] = q[q.size()-1] | 256;
        m_in = 0; m_has = 0;
      end else if (dec_vld && (dec_sof || m_in)) begin
        cn = dec_sof ? 1 : (m_cnt < 65535 ? m_cnt + 1 : m_cnt);
        over = cn > lim;
        blocked = over || (m_ovf && !dec_sof);
        if (over) s_len = 1;
        wrote = 0;
        if (!blocked) begin
          if (full0) s_ovr = 1;
          else begin q.push_back({23'd0, dec_eof, dec_byte}); wrote = 1; end
        end
        m_ovf = over || (m_ovf && !dec_sof);
        m_has = dec_eof ? 0 : ((m_has && !dec_sof) || wrote);
        m_in = !dec_eof;
        m_cnt = cn;
      end
      if (crc_done && crc_bad) s_crc = 1;
      f_len = (f_len && !stat_rd) || s_len;
      f_phy = (f_phy && !stat_rd) || s_phy;
      f_crc = (f_crc && !stat_rd) || s_crc;
      f_ovr = (f_ovr && !stat_rd) || s_ovr;
    end
    #2;
    check("R3 R2 bit7 end tag at head", status[7], (q.size() > 0) ? q[0][8] : 0);
    check("R12 bit6 tx shift empty", status[6], tx_shift_empty);
    check("R12 bit5 tx hold empty", status[5], tx_hold_empty);
    check("R4 bit4 length exceeded", status[4], f_len);
    check("R6 bit3 physical error", status[3], f_phy);
    check("R7 bit2 CRC error", status[2], f_crc);
    check("R8 bit1 overrun", status[1], f_ovr);
    check("R8 bit0 data ready", status[0], q.size() > 0);
    if (exp_rd_vld) begin
      check("R11 popped data", fifo_rd_data, exp_rd & 255);
      check("R3 popped end tag", fifo_rd_last, exp_rd[8]);
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input bit v, input logic [7:0] b, input bit s, input bit e,
                      input bit ill, input bit cd, input bit cb, input bit rd, input bit sr);
    @(negedge clk);
    dec_vld = v; dec_byte = b; dec_sof = s; dec_eof = e; dec_illegal = ill;
    crc_done = cd; crc_bad = cb; fifo_rd = rd; stat_rd = sr;
  endtask
  task automatic idle(); step(0,0,0,0,0,0,0,0,0); endtask
  task automatic bytein(input logic [7:0] b, input bit s, input bit e); step(1,b,s,e,0,0,0,0,0); endtask
  task automatic pop(); step(0,0,0,0,0,0,0,1,0); endtask
  task automatic sread(); step(0,0,0,0,0,0,0,0,1); endtask
  task automatic settle(); @(posedge clk); #3; endtask
  task automatic drain(); for (int i = 0; i < DEPTH + 2; i++) pop(); idle(); endtask
  task automatic setlim(input int l); @(negedge clk); max_len_lo = l[7:0]; max_len_hi = l[15:8]; endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    idle(); settle();
    check("R1 reset status", status, 0);

    // two frames queued back to back
    bytein(8'h11,1,0); bytein(8'h12,0,0); bytein(8'h13,0,1);
    bytein(8'h21,1,0); bytein(8'h22,0,1); idle(); settle();
    check("R3 head not last", status[7], 0);
    pop(); pop(); settle();
    check("R3 head is last of first frame", status[7], 1);
    drain(); settle();
    check("R11 empty after drain", status[0], 0);
    pop(); settle();
    check("R11 pop on empty has no effect", status[0], 0);

    // length limit
    setlim(2);
    bytein(8'h31,1,0); bytein(8'h32,0,0); bytein(8'h33,0,0); bytein(8'h34,0,1); idle(); settle();
    check("R4 limit 2 exceeded", status[4], 1);
    pop(); pop(); idle(); settle();
    check("R5 no bytes after exceed", status[0], 0);
    bytein(8'h41,1,1); idle(); settle();
    check("R5 next frame written", status[7:0] & 8'h81, 8'h81);
    sread(); drain();

    // limit 0, then illegal with nothing written
    bytein(8'h51,1,1); idle();
    setlim(0);
    bytein(8'h52,1,0); step(0,0,0,0,1,0,0,0,0); idle(); settle();
    check("R6 no tag when frame wrote nothing", status[7], 1);
    pop(); idle(); settle();
    check("R6 queue holds only earlier frame", status[0], 0);
    setlim(16'hFFFF); sread();

    // illegal mid-frame; byte in same cycle discarded
    bytein(8'h61,1,0); bytein(8'h62,0,0); step(1,8'h63,0,0,1,0,0,0,0); idle(); settle();
    check("R6 phy flag", status[3], 1);
    pop(); settle();
    check("R6 forced end tags latest byte", status[7], 1);
    drain();

    // CRC and set-wins on read
    step(0,0,0,0,0,1,0,0,0); settle();
    check("R7 crc good leaves flag", status[2], 0);
    step(0,0,0,0,0,1,1,0,1); settle();
    check("R9 set in read cycle stays", status[2], 1);
    sread(); settle();
    check("R9 read clears flags", status[4:1], 0);

    // bytes outside a frame
    bytein(8'h71,0,0); bytein(8'h72,0,1); idle(); settle();
    check("R10 bytes outside frame ignored", status[0], 0);

    // overrun, including pop while full
    bytein(8'h80,1,0);
    for (int i = 1; i < DEPTH; i++) bytein(8'h80 + 8'(i), 0, 0);
    step(1,8'hEE,0,0,0,0,0,1,0); idle(); settle();
    check("R8 overrun while full despite pop", status[1], 1);
    drain(); sread();
    step(0,0,0,0,0,0,0,0,0); tx_shift_empty = 1; settle();
    check("R12 tx shift pass-through", status[6], 1);
    tx_shift_empty = 0; tx_hold_empty = 1; settle();
    check("R12 tx hold pass-through", status[5], 1);

    // mixed random traffic, model compared every clock
    setlim(9);
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 100;
      step(r < 70, 8'($urandom), ($urandom % 8) == 0, ($urandom % 6) == 0,
           ($urandom % 40) == 0, ($urandom % 20) == 0, $urandom % 2,
           ($urandom % 100) < 45, ($urandom % 12) == 0);
      if (i % 500 == 0) begin tx_shift_empty = $urandom % 2; tx_hold_empty = $urandom % 2; end
    end
    drain(); idle(); settle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule